// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks one PLL through a safe change of divider settings when asked to. A single start pulse carries the requested reference divider (NR), feedback multiplier (NF) and post divider (NO). The sequencer first checks that the request gives a legal oscillator frequency and a legal output frequency. If it does, the block moves the PLL's consumers onto the slow bypass clock, holds the PLL in reset and writes the new divider and loop-bandwidth fields. It then waits a fixed number of microseconds, releases reset and polls the lock input once per microsecond. Only after lock does it put the mode back to normal.

The sequencer is timed by a one-cycle microsecond tick from outside, so it does not depend on the system clock rate. An illegal request or a lock that does not arrive within a programmable number of microseconds ends the sequence with an error flag. The analog PLL is outside the block.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, `mode` is 0, `pll_rst` is 0, all divider and bandwidth fields are 0, and `busy`, `done` and `err` are 0.
- R2: On an accepted start, `mode` is set to code 0 (bypass) before `pll_rst` rises. The divider and bandwidth fields change only while `pll_rst` is 1, and `pll_rst` is 1 only while `mode` is 0.
- R3: A legal request loads `nr_field` = NR-1 (6 bits), `no_field` = NO-1 (4 bits), `nf_field` = NF-1 (13 bits) and `bw_field` = floor(NF/2)-1 (12 bits).
- R4: After the fields are loaded, `pll_rst` stays high until SETTLE_US ticks (default 10) have been counted, and it falls in the second cycle after that tick.
- R5: After `pll_rst` is released, `lock_i` is sampled only in cycles where `us_tick` is 1. Once a tick sees lock, `mode` becomes code 1 (normal) and `done` becomes 1 two cycles after that tick.
- R6: A request whose VCO frequency, REF_KHZ*NF/NR, lies below VCO_MIN_KHZ (440 MHz) or above VCO_MAX_KHZ (2200 MHz) sets `err` and returns to idle. `mode`, `pll_rst` and every field are left unchanged.
- R7: A request whose output frequency, VCO/NO, lies below OUT_MIN_KHZ or above OUT_MAX_KHZ is rejected in the same way as in R6. Exact boundary values are legal.
- R8: NO must be 1 or even. A zero divisor, or a divisor whose value minus one does not fit its field, is also illegal and is rejected as in R6.
- R9: A start pulse while `busy` is 1 is ignored, and the sequence in progress completes with its original values.
- R10: If `tmo_limit` ticks after release pass without lock, `err` is set and `mode` stays at 0. Lock seen on the tick that would expire the limit counts as success. A `tmo_limit` of 0 disables the timeout.
- R11: `done` and `err` are never both 1. Each holds until the next accepted start, which clears both in the cycle that `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| req_nr | input | 7 | Requested reference divider NR |
| req_nf | input | 14 | Requested feedback multiplier NF |
| req_no | input | 5 | Requested post divider NO |
| lock_i | input | 1 | Lock status from the PLL |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| tmo_limit | input | 8 | Lock timeout in microseconds, 0 disables it |
| nr_field | output | 6 | NR-1 |
| no_field | output | 4 | NO-1 |
| nf_field | output | 13 | NF-1 |
| bw_field | output | 12 | NF/2-1 |
| pll_rst | output | 1 | PLL reset bit |
| mode | output | 2 | 0 = bypass, 1 = normal |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last sequence finished locked |
| err | output | 1 | Last sequence was rejected or timed out |

## Verification
Two things can fall in the same lock-poll tick: the lock sample and the expiry of the timeout counter. The bench sets its lock model so that lock first shows on exactly the tick that reaches `tmo_limit`, and expects the sequence to finish in normal mode with `done` set. It then delays lock by one more tick and expects `err` with the mode left at bypass. A second overlap is a start pulse that arrives while a sequence is running. The bench checks this at the ports: the fields and mode at completion must come from the first request.

// File: rtl/pll_reprog_pkg.sv
`timescale 1ns/1ps
package pll_reprog_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CHECK,
      ST_BYPASS,
      ST_HOLD,
      ST_LOAD,
      ST_SETTLE,
      ST_RELEASE,
      ST_LOCKWAIT,
      ST_RUN
   } seq_state_e;

   localparam logic [1:0] MODE_BYPASS = 2'd0;
   localparam logic [1:0] MODE_RUN    = 2'd1;

endpackage

// File: rtl/pll_cfg_check.sv
`timescale 1ns/1ps
module pll_cfg_check #(
   parameter int REF_KHZ     = 24000,
   parameter int VCO_MIN_KHZ = 440000,
   parameter int VCO_MAX_KHZ = 2200000,
   parameter int OUT_MIN_KHZ = 27500,
   parameter int OUT_MAX_KHZ = 2200000,
   parameter int NR_W        = 6,
   parameter int NO_W        = 4,
   parameter int NF_W        = 13
) (
   input  logic [NR_W:0] nr,
   input  logic [NO_W:0] no,
   input  logic [NF_W:0] nf,
   output logic          legal
);

   localparam int PW = 64;

   logic          nr_fits, no_fits, nf_fits, no_parity_ok;
   logic [PW-1:0] vco_num, vco_lo, vco_hi, out_lo, out_hi, nr_no;
   logic          vco_ok, out_ok;

   // a value fits when it is nonzero and at most 2**W (so value-1 fits W bits)
   assign nr_fits = (nr != '0) && (!nr[NR_W] || (nr[NR_W-1:0] == '0));
   assign no_fits = (no != '0) && (!no[NO_W] || (no[NO_W-1:0] == '0));
   assign nf_fits = (nf != '0) && (!nf[NF_W] || (nf[NF_W-1:0] == '0));

   assign no_parity_ok = (no == (NO_W+1)'(1)) || !no[0];

   // range checks done by cross-multiplying, no division
   assign vco_num = PW'(REF_KHZ) * PW'(nf);
   assign vco_lo  = PW'(VCO_MIN_KHZ) * PW'(nr);
   assign vco_hi  = PW'(VCO_MAX_KHZ) * PW'(nr);
   assign nr_no   = PW'(nr) * PW'(no);
   assign out_lo  = PW'(OUT_MIN_KHZ) * nr_no;
   assign out_hi  = PW'(OUT_MAX_KHZ) * nr_no;

   assign vco_ok = (vco_num >= vco_lo) && (vco_num <= vco_hi);
   assign out_ok = (vco_num >= out_lo) && (vco_num <= out_hi);

   assign legal = nr_fits && no_fits && nf_fits && no_parity_ok && vco_ok && out_ok;

endmodule

// File: rtl/pll_field_pack.sv
`timescale 1ns/1ps
module pll_field_pack #(
   parameter int NR_W = 6,
   parameter int NO_W = 4,
   parameter int NF_W = 13,
   parameter int BW_W = 12
) (
   input  logic [NR_W:0]   nr,
   input  logic [NO_W:0]   no,
   input  logic [NF_W:0]   nf,
   output logic [NR_W-1:0] nr_f,
   output logic [NO_W-1:0] no_f,
   output logic [NF_W-1:0] nf_f,
   output logic [BW_W-1:0] bw_f
);

   localparam int HALF_W = NF_W;

   logic [HALF_W-1:0] nf_half;

   assign nf_half = HALF_W'(nf >> 1);

   assign nr_f = NR_W'(nr - 1'b1);
   assign no_f = NO_W'(no - 1'b1);
   assign nf_f = NF_W'(nf - 1'b1);

   generate
      if (BW_W >= HALF_W) begin : g_bw_wide
         assign bw_f = BW_W'(nf_half) - BW_W'(1);
      end else begin : g_bw_narrow
         logic [HALF_W-1:0] half_m1;
         assign half_m1 = nf_half - HALF_W'(1);
         assign bw_f    = half_m1[BW_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/pll_us_timer.sv
`timescale 1ns/1ps
module pll_us_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (tick)
         count <= count + CNT_W'(1);
   end

endmodule

// File: rtl/pll_reprog_seq.sv
`timescale 1ns/1ps
module pll_reprog_seq
   import pll_reprog_pkg::*;
#(
   parameter int REF_KHZ     = 24000,
   parameter int VCO_MIN_KHZ = 440000,
   parameter int VCO_MAX_KHZ = 2200000,
   parameter int OUT_MIN_KHZ = 27500,
   parameter int OUT_MAX_KHZ = 2200000,
   parameter int NR_W        = 6,
   parameter int NO_W        = 4,
   parameter int NF_W        = 13,
   parameter int BW_W        = 12,
   parameter int SETTLE_US   = 10,
   parameter int TMO_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NR_W:0]     req_nr,
   input  logic [NF_W:0]     req_nf,
   input  logic [NO_W:0]     req_no,
   input  logic              lock_i,
   input  logic              us_tick,
   input  logic [TMO_W-1:0]  tmo_limit,
   output logic [NR_W-1:0]   nr_field,
   output logic [NO_W-1:0]   no_field,
   output logic [NF_W-1:0]   nf_field,
   output logic [BW_W-1:0]   bw_field,
   output logic              pll_rst,
   output logic [1:0]        mode,
   output logic              busy,
   output logic              done,
   output logic              err
);

   localparam int SET_W = $clog2(SETTLE_US + 1);
   localparam int CNT_W = (TMO_W > SET_W) ? TMO_W : SET_W;
   localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_US - 1);

   generate
      if (SETTLE_US < 1) begin : g_bad_settle
         $error("pll_reprog_seq: SETTLE_US must be at least 1");
      end
      if (VCO_MIN_KHZ > VCO_MAX_KHZ) begin : g_bad_vco
         $error("pll_reprog_seq: VCO range is empty");
      end
      if (OUT_MIN_KHZ > OUT_MAX_KHZ) begin : g_bad_out
         $error("pll_reprog_seq: output range is empty");
      end
      if (NR_W < 1 || NO_W < 1 || NF_W < 2 || BW_W < 1) begin : g_bad_width
         $error("pll_reprog_seq: field widths too small");
      end
   endgenerate

   seq_state_e state;

   logic [NR_W:0]    nr_q;
   logic [NO_W:0]    no_q;
   logic [NF_W:0]    nf_q;
   logic             cfg_legal;
   logic [NR_W-1:0]  nr_new;
   logic [NO_W-1:0]  no_new;
   logic [NF_W-1:0]  nf_new;
   logic [BW_W-1:0]  bw_new;
   logic             tmr_clr;
   logic [CNT_W-1:0] tmr_count;
   logic             settle_end;
   logic             tmo_hit;

   pll_cfg_check #(
      .REF_KHZ    (REF_KHZ),
      .VCO_MIN_KHZ(VCO_MIN_KHZ),
      .VCO_MAX_KHZ(VCO_MAX_KHZ),
      .OUT_MIN_KHZ(OUT_MIN_KHZ),
      .OUT_MAX_KHZ(OUT_MAX_KHZ),
      .NR_W       (NR_W),
      .NO_W       (NO_W),
      .NF_W       (NF_W)
   ) u_check (
      .nr   (nr_q),
      .no   (no_q),
      .nf   (nf_q),
      .legal(cfg_legal)
   );

   pll_field_pack #(
      .NR_W(NR_W),
      .NO_W(NO_W),
      .NF_W(NF_W),
      .BW_W(BW_W)
   ) u_pack (
      .nr  (nr_q),
      .no  (no_q),
      .nf  (nf_q),
      .nr_f(nr_new),
      .no_f(no_new),
      .nf_f(nf_new),
      .bw_f(bw_new)
   );

   // one counter serves both the settle wait and the lock timeout
   assign tmr_clr = (state == ST_LOAD) || (state == ST_RELEASE);

   pll_us_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (tmr_clr),
      .tick (us_tick),
      .count(tmr_count)
   );

   assign settle_end = us_tick && (tmr_count == SETTLE_LAST);
   assign tmo_hit    = (tmo_limit != '0) &&
                       (tmr_count == (CNT_W'(tmo_limit) - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         nr_q     <= '0;
         no_q     <= '0;
         nf_q     <= '0;
         nr_field <= '0;
         no_field <= '0;
         nf_field <= '0;
         bw_field <= '0;
         pll_rst  <= 1'b0;
         mode     <= MODE_BYPASS;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  nr_q  <= req_nr;
                  no_q  <= req_no;
                  nf_q  <= req_nf;
                  done  <= 1'b0;
                  err   <= 1'b0;
                  state <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (!cfg_legal) begin
                  err   <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_BYPASS;
               end
            end
            ST_BYPASS: begin
               mode  <= MODE_BYPASS;
               state <= ST_HOLD;
            end
            ST_HOLD: begin
               pll_rst <= 1'b1;
               state   <= ST_LOAD;
            end
            ST_LOAD: begin
               nr_field <= nr_new;
               no_field <= no_new;
               nf_field <= nf_new;
               bw_field <= bw_new;
               state    <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (settle_end)
                  state <= ST_RELEASE;
            end
            ST_RELEASE: begin
               pll_rst <= 1'b0;
               state   <= ST_LOCKWAIT;
            end
            ST_LOCKWAIT: begin
               if (us_tick) begin
                  if (lock_i) begin
                     state <= ST_RUN;
                  end else if (tmo_hit) begin
                     err   <= 1'b1;
                     state <= ST_IDLE;
                  end
               end
            end
            ST_RUN: begin
               mode  <= MODE_RUN;
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pll_reprog_seq_chk.sv
`timescale 1ns/1ps
module pll_reprog_seq_chk
   import pll_reprog_pkg::*;
#(
   parameter int NR_W      = 6,
   parameter int NO_W      = 4,
   parameter int NF_W      = 13,
   parameter int SETTLE_US = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            us_tick,
   input logic            lock_i,
   input logic            pll_rst,
   input logic [1:0]      mode,
   input logic            done,
   input logic            err,
   input logic [NR_W-1:0] nr_field,
   input logic [NO_W-1:0] no_field,
   input logic [NF_W-1:0] nf_field
);

   logic [15:0] rst_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rst_ticks <= '0;
      else if (!pll_rst)
         rst_ticks <= '0;
      else if (us_tick && rst_ticks != 16'hFFFF)
         rst_ticks <= rst_ticks + 16'd1;
   end

   // R1 state holds at time zero of the run: nothing changes fields without reset
   p_fields_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((nr_field != $past(nr_field)) || (no_field != $past(no_field)) ||
       (nf_field != $past(nf_field))) |-> pll_rst);

   p_reset_in_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pll_rst |-> (mode == MODE_BYPASS));

   p_settle_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_rst) |-> (32'(rst_ticks) >= SETTLE_US));

   p_run_after_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_RUN) && ($past(mode) != MODE_RUN)) |->
         ($past(lock_i, 2) && $past(us_tick, 2)));

   p_err_keeps_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> ((mode == $past(mode)) && !pll_rst));

   p_done_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
   .NR_W     (NR_W),
   .NO_W     (NO_W),
   .NF_W     (NF_W),
   .SETTLE_US(SETTLE_US)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .us_tick (us_tick),
   .lock_i  (lock_i),
   .pll_rst (pll_rst),
   .mode    (mode),
   .done    (done),
   .err     (err),
   .nr_field(nr_field),
   .no_field(no_field),
   .nf_field(nf_field)
);

// File: tb/sim_pll_reprog_seq.sv
`timescale 1ns/1ps
module sim_pll_reprog_seq;

   typedef struct {
      int    err;
      int    mode;
      int    nr;
      int    no;
      int    nf;
      int    bw;
      string rq;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [6:0]  req_nr;
   logic [13:0] req_nf;
   logic [4:0]  req_no;
   logic        lock_i;
   logic        us_tick;
   logic [7:0]  tmo_limit;
   logic [5:0]  nr_field;
   logic [3:0]  no_field;
   logic [12:0] nf_field;
   logic [11:0] bw_field;
   logic        pll_rst;
   logic [1:0]  mode;
   logic        busy;
   logic        done;
   logic        err;

   int   checks = 0;
   int   fails  = 0;
   exp_t sb_q[$];

   bit   lock_en  = 1'b1;
   int   lock_dly = 2;

   int   m_mode = 0;
   int   m_nr = 0, m_no = 0, m_nf = 0, m_bw = 0;

   initial forever #2.5 clk = ~clk;

   pll_reprog_seq #(.OUT_MIN_KHZ(100000)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .req_nr   (req_nr),
      .req_nf   (req_nf),
      .req_no   (req_no),
      .lock_i   (lock_i),
      .us_tick  (us_tick),
      .tmo_limit(tmo_limit),
      .nr_field (nr_field),
      .no_field (no_field),
      .nf_field (nf_field),
      .bw_field (bw_field),
      .pll_rst  (pll_rst),
      .mode     (mode),
      .busy     (busy),
      .done     (done),
      .err      (err)
   );

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // microsecond tick: one cycle high in every eight
   initial begin
      us_tick = 1'b0;
      forever begin
         repeat (7) @(negedge clk);
         us_tick = 1'b1;
         @(negedge clk);
         us_tick = 1'b0;
      end
   end

   // lock model: lock goes high lock_dly ticks after reset release, visible on the next tick
   initial begin
      lock_i = 1'b0;
      forever begin
         wait (pll_rst === 1'b1);
         lock_i = 1'b0;
         wait (pll_rst === 1'b0);
         if (lock_en) begin
            repeat (lock_dly) @(posedge us_tick);
            @(negedge clk);
            @(negedge clk);
            lock_i = 1'b1;
         end
      end
   end

   // monitor: ordering, settle window and scoreboard at completion
   initial begin
      logic        p_busy = 1'b0;
      logic        p_rst  = 1'b0;
      logic [34:0] p_fields = '0;
      int          rticks = 0;
      forever begin
         @(negedge clk);
         if (rst_n === 1'b1) begin
            if (pll_rst && !p_rst) begin
               chk("R2", "mode at reset rise", 32'(mode), 32'd0);
               chk("R2", "fields unchanged before reset", 32'({nr_field, no_field, nf_field} != p_fields), 32'd0);
               rticks = 0;
            end
            if (pll_rst && us_tick) rticks++;
            if (!pll_rst && p_rst)
               chk("R4", $sformatf("ticks under reset=%0d within 10..11", rticks),
                   32'(rticks >= 10 && rticks <= 11), 32'd1);
            if (p_busy && !busy) begin
               if (sb_q.size() == 0) begin
                  chk("R9", "completion with empty scoreboard", 32'd1, 32'd0);
               end else begin
                  exp_t e;
                  e = sb_q.pop_front();
                  chk(e.rq, "err",      32'(err),      e.err);
                  chk(e.rq, "done",     32'(done),     32'(e.err == 0));
                  chk(e.rq, "mode",     32'(mode),     e.mode);
                  chk(e.rq, "pll_rst",  32'(pll_rst),  32'd0);
                  chk(e.rq, "nr_field", 32'(nr_field), e.nr);
                  chk(e.rq, "no_field", 32'(no_field), e.no);
                  chk(e.rq, "nf_field", 32'(nf_field), e.nf);
                  chk(e.rq, "bw_field", 32'(bw_field), e.bw);
               end
            end
         end
         p_busy   = busy;
         p_rst    = pll_rst;
         p_fields = {nr_field, no_field, nf_field};
      end
   end

   // kind: 0 legal and locks, 1 illegal request, 2 lock timeout
   task automatic run(input int nr, input int nf, input int no, input int kind,
                      input bit lk, input int ldly, input int tmo, input bit poke,
                      input string rq);
      exp_t e;
      if (kind != 1) begin
         m_nr = nr - 1;
         m_no = no - 1;
         m_nf = nf - 1;
         m_bw = nf / 2 - 1;
         m_mode = (kind == 0) ? 1 : 0;
      end
      e.err  = (kind != 0) ? 1 : 0;
      e.mode = m_mode;
      e.nr   = m_nr;
      e.no   = m_no;
      e.nf   = m_nf;
      e.bw   = m_bw;
      e.rq   = rq;
      lock_en   = lk;
      lock_dly  = ldly;
      tmo_limit = 8'(tmo);
      @(negedge clk);
      req_nr = 7'(nr);
      req_nf = 14'(nf);
      req_no = 5'(no);
      start  = 1'b1;
      sb_q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      chk("R11", "busy after start", 32'(busy), 32'd1);
      chk("R11", "done and err cleared on start", 32'({done, err}), 32'd0);
      if (poke) begin
         repeat (3) @(negedge clk);
         req_nr = 7'd1;
         req_nf = 14'd92;
         req_no = 5'd3;
         start  = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (busy == 1'b0);
      repeat (3) @(negedge clk);
      chk("R11", "result flags held", 32'({done, err}), (kind == 0) ? 32'd2 : 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      req_nr = '0;
      req_nf = '0;
      req_no = '0;
      tmo_limit = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset outputs",
          32'({nr_field, no_field, nf_field, bw_field, pll_rst, mode, busy, done, err}), 32'd0);

      run(1, 75, 1, 0, 1'b1, 2, 20, 1'b0, "R3");   // 1800 MHz, fields 0,0,74,36
      run(2, 25, 1, 1, 1'b1, 2, 20, 1'b0, "R6");   // VCO 300 MHz too low
      run(9, 500, 2, 0, 1'b1, 3, 20, 1'b0, "R5");  // 1333 MHz VCO, fields 8,1,499,249
      run(3, 55, 4, 0, 1'b1, 2, 20, 1'b0, "R6");   // VCO exactly 440 MHz legal
      run(3, 54, 1, 1, 1'b1, 2, 20, 1'b0, "R6");   // VCO 432 MHz
      run(1, 92, 1, 1, 1'b1, 2, 20, 1'b0, "R6");   // VCO 2208 MHz
      run(1, 91, 1, 0, 1'b1, 2, 20, 1'b0, "R7");   // output 2184 MHz legal
      run(1, 50, 16, 1, 1'b1, 2, 20, 1'b0, "R7");  // output 75 MHz below 100 MHz
      run(1, 50, 12, 0, 1'b1, 2, 20, 1'b0, "R7");  // output exactly 100 MHz
      run(1, 50, 3, 1, 1'b1, 2, 20, 1'b0, "R8");   // odd NO
      run(1, 75, 0, 1, 1'b1, 2, 20, 1'b0, "R8");   // zero NO
      run(0, 75, 1, 1, 1'b1, 2, 20, 1'b0, "R8");   // zero NR
      run(1, 75, 18, 1, 1'b1, 2, 20, 1'b0, "R8");  // NO-1 does not fit 4 bits
      run(1, 75, 2, 2, 1'b0, 0, 5, 1'b0, "R10");   // no lock, timeout
      run(1, 75, 1, 0, 1'b1, 4, 5, 1'b0, "R10");   // lock on the expiry tick wins
      run(1, 75, 2, 2, 1'b1, 5, 5, 1'b0, "R10");   // lock one tick late
      run(1, 75, 1, 0, 1'b1, 30, 0, 1'b0, "R10");  // zero limit waits
      run(9, 500, 2, 0, 1'b1, 2, 20, 1'b1, "R9");  // start while busy ignored

      repeat (20) @(negedge clk);
      chk("R9", "scoreboard drained", 32'(sb_q.size()), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule